// File: doc/BRIEF.md
# Scalar Operand Resolver with Inline Constants

The block turns an operand selector code from an instruction into the 32-bit or 64-bit value that the instruction consumes. A selector can name a plain scalar register, one of three reserved registers (vector condition, flat-scratch high, flat-scratch low), the 64-bit execution mask, a miscellaneous register, the instruction's literal word, or an inline floating-point constant. The bit pattern of an inline constant depends on the operand width. The read side is purely combinational. The block sends out the physical scalar-register indices it needs, and the scalar register file returns the two dwords in the same cycle.

A scalar register index is computed as the wavefront's base plus a logical index. For a plain register, the logical index is the selector plus the dword number. The reserved registers sit just below the wavefront's reserved-register count. The write side sends the write data, with an optional single-bit replacement applied, to whichever target the selector names: the scalar register file, the miscellaneous path, or the internal execution-mask register. The execution-mask register is the only storage in the block.

Selector codes: `0x00`..`NUM_SREG-1` plain registers, `0x66` flat-scratch low, `0x67` flat-scratch high, `0x6A` vector condition, `0x70`..`0x7D` miscellaneous (address = selector bits 3:0), `0x7E` execution mask, `0xF0`..`0xF7` inline constants, `0xF8` reciprocal of two pi, `0xFD`..`0xFF` literal. Every other code is illegal.

Top module: `sopnd_resolver`

## Requirements
- R1: A selector below NUM_SREG (default 102) drives `srf_idx_lo` = base + selector and `srf_idx_hi` = base + selector + 1. The read value is {`srf_rd_hi`, `srf_rd_lo`} when `wide`=1, and {32'b0, `srf_rd_lo`} when `wide`=0.
- R2: Selector 0x6A (vector condition) reads logical register R-2+dword, where R is `rsv_cnt`. The physical index is base + that value, and both widths are allowed.
- R3: Selector 0x67 (flat-scratch high) reads logical R-3+dword at either width. Selector 0x66 (flat-scratch low) reads logical R-4, but only at `wide`=0; at `wide`=1 it sets `err`.
- R4: Selectors 0xF0..0xF7 give +0.5, -0.5, +1, -1, +2, -2, +4, -4 in that order. At `wide`=0 each value is an IEEE single in the low dword, with the upper dword zero.
- R5: At `wide`=1, the same selectors give the IEEE double of the same value.
- R6: Selector 0xF8 gives 0x3E22F983 at `wide`=0 and 0x3FC45F306DC9C882 at `wide`=1.
- R7: Selectors 0xFD..0xFF return {32'b0, `lit`} at `wide`=0. At `wide`=1 they set `err`.
- R8: Selector 0x7E at `wide`=1 reads the 64-bit execution mask, which is all ones after reset. At `wide`=0 it sets `err`.
- R9: A write (`wr_en`=1) to 0x7E at `wide`=1 replaces the mask at the next clock edge. At `wide`=0 the write sets `err` and leaves the mask unchanged.
- R10: Selectors 0x70..0x7D read {32'b0, `misc_rd`} and drive `misc_addr` = selector bits 3:0. A write to them raises `misc_we` with `misc_wdata` = the low dword of the write data.
- R11: A write to a plain or reserved register raises `srf_we_lo`. It also raises `srf_we_hi` when `wide`=1, with `srf_wdata` carrying the write data. At most one of `srf_we_lo` and `misc_we` is high.
- R12: With `bit_en`=1, bit `bit_pos` of the write data is replaced by `bit_val` before it reaches any target. At `wide`=0 a `bit_pos` of 32 or more has no effect.
- R13: An illegal selector or width sets `err`, forces `rd_data` to zero and blocks every write. Writes to constant, reciprocal-of-two-pi and literal selectors raise no write enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sel | input | SEL_W | Operand selector code |
| wide | input | 1 | 1 = two-dword operand, 0 = one dword |
| lit | input | 32 | Literal word from the instruction |
| rsv_cnt | input | IDX_W | Reserved scalar register count of the wavefront |
| sgpr_base | input | IDX_W | Wavefront's first physical scalar register |
| srf_idx_lo | output | IDX_W | Physical index of the low dword |
| srf_idx_hi | output | IDX_W | Physical index of the high dword |
| srf_rd_lo | input | 32 | Register file data at srf_idx_lo |
| srf_rd_hi | input | 32 | Register file data at srf_idx_hi |
| misc_rd | input | 32 | Miscellaneous register read data |
| wr_en | input | 1 | Write the operand |
| wr_data | input | 64 | Write data |
| bit_en | input | 1 | Replace one bit of the write data |
| bit_pos | input | 6 | Bit to replace |
| bit_val | input | 1 | Value of the replaced bit |
| rd_data | output | 64 | Resolved operand value |
| err | output | 1 | Illegal selector/width combination |
| srf_we_lo | output | 1 | Register file write, low dword |
| srf_we_hi | output | 1 | Register file write, high dword |
| srf_wdata | output | 64 | Register file write data |
| misc_we | output | 1 | Miscellaneous register write |
| misc_addr | output | MISC_W | Miscellaneous register address |
| misc_wdata | output | 32 | Miscellaneous write data |
| exec_mask | output | 64 | Current execution mask |

## Verification
The execution mask is the only state, so a corrupted mask or an enable that was missed is first visible on `exec_mask` one edge after the write, and then on `rd_data` when selector 0x7E is read. The rest of the block is combinational. A wrong decode or wrong index arithmetic therefore shows in the same cycle on `rd_data`, `err`, or the index outputs. The bench compares these against a register-file model whose contents are a function of the index. The sweep covers every selector code at both widths under two reserved-count and base settings.

// File: rtl/sopnd_resolver.sv
module sopnd_resolver #(
  parameter int SEL_W = 8,
  parameter int IDX_W = 7,
  parameter int NUM_SREG = 102,
  parameter int MISC_W = 4,
  parameter logic [63:0] EXEC_RST = '1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SEL_W-1:0]  sel,
  input  logic              wide,
  input  logic [31:0]       lit,
  input  logic [IDX_W-1:0]  rsv_cnt,
  input  logic [IDX_W-1:0]  sgpr_base,
  output logic [IDX_W-1:0]  srf_idx_lo,
  output logic [IDX_W-1:0]  srf_idx_hi,
  input  logic [31:0]       srf_rd_lo,
  input  logic [31:0]       srf_rd_hi,
  input  logic [31:0]       misc_rd,
  input  logic              wr_en,
  input  logic [63:0]       wr_data,
  input  logic              bit_en,
  input  logic [5:0]        bit_pos,
  input  logic              bit_val,
  output logic [63:0]       rd_data,
  output logic              err,
  output logic              srf_we_lo,
  output logic              srf_we_hi,
  output logic [63:0]       srf_wdata,
  output logic              misc_we,
  output logic [MISC_W-1:0] misc_addr,
  output logic [31:0]       misc_wdata,
  output logic [63:0]       exec_mask
);

  localparam logic [SEL_W-1:0] S_FLAT_LO = SEL_W'('h66);
  localparam logic [SEL_W-1:0] S_FLAT_HI = SEL_W'('h67);
  localparam logic [SEL_W-1:0] S_VCOND   = SEL_W'('h6A);
  localparam logic [SEL_W-1:0] S_MISC_LO = SEL_W'('h70);
  localparam logic [SEL_W-1:0] S_MISC_HI = SEL_W'('h7D);
  localparam logic [SEL_W-1:0] S_EXEC    = SEL_W'('h7E);
  localparam logic [SEL_W-1:0] S_K_LO    = SEL_W'('hF0);
  localparam logic [SEL_W-1:0] S_K_HI    = SEL_W'('hF7);
  localparam logic [SEL_W-1:0] S_PI      = SEL_W'('hF8);
  localparam logic [SEL_W-1:0] S_LIT_LO  = SEL_W'('hFD);
  localparam logic [SEL_W-1:0] S_LIT_HI  = SEL_W'('hFF);
  localparam logic [31:0] PI_SP = 32'h3E22F983;
  localparam logic [63:0] PI_DP = 64'h3FC45F306DC9C882;

  typedef enum logic [2:0] {
    K_SREG, K_RSV, K_EXEC, K_CONST, K_PI, K_LIT, K_MISC, K_BAD
  } kind_t;

  kind_t            kind;
  logic             narrow_only;
  logic             need_wide;
  logic [IDX_W-1:0] rsv_off;
  logic [IDX_W-1:0] lo_log;
  logic [63:0]      raw;
  logic [63:0]      eff;
  logic [63:0]      exec_q;
  logic             to_srf;
  logic [1:0]       kmag;

  always_comb begin
    kind        = K_BAD;
    narrow_only = 1'b0;
    need_wide   = 1'b0;
    rsv_off     = '0;
    if (int'(sel) < NUM_SREG) begin
      kind = K_SREG;
    end else if (sel == S_FLAT_LO) begin
      kind = K_RSV; rsv_off = rsv_cnt - IDX_W'(4); narrow_only = 1'b1;
    end else if (sel == S_FLAT_HI) begin
      kind = K_RSV; rsv_off = rsv_cnt - IDX_W'(3);
    end else if (sel == S_VCOND) begin
      kind = K_RSV; rsv_off = rsv_cnt - IDX_W'(2);
    end else if (sel >= S_MISC_LO && sel <= S_MISC_HI) begin
      kind = K_MISC;
    end else if (sel == S_EXEC) begin
      kind = K_EXEC; need_wide = 1'b1;
    end else if (sel >= S_K_LO && sel <= S_K_HI) begin
      kind = K_CONST;
    end else if (sel == S_PI) begin
      kind = K_PI;
    end else if (sel >= S_LIT_LO && sel <= S_LIT_HI) begin
      kind = K_LIT; narrow_only = 1'b1;
    end
  end

  assign err    = (kind == K_BAD) | (narrow_only & wide) | (need_wide & ~wide);
  assign to_srf = (kind == K_SREG) | (kind == K_RSV);
  assign lo_log = (kind == K_SREG) ? sel[IDX_W-1:0] : rsv_off;
  assign srf_idx_lo = sgpr_base + lo_log;
  assign srf_idx_hi = sgpr_base + lo_log + IDX_W'(1);
  assign kmag = sel[2:1];

  always_comb begin
    case (kind)
      K_SREG, K_RSV: raw = {srf_rd_hi, srf_rd_lo};
      K_EXEC:        raw = exec_q;
      K_CONST:       raw = wide ? {sel[0], 11'd1022 + {9'd0, kmag}, 52'd0}
                                : {32'd0, sel[0], 8'd126 + {6'd0, kmag}, 23'd0};
      K_PI:          raw = wide ? PI_DP : {32'd0, PI_SP};
      K_LIT:         raw = {32'd0, lit};
      K_MISC:        raw = {32'd0, misc_rd};
      default:       raw = '0;
    endcase
  end

  assign rd_data = err ? 64'd0 : (wide ? raw : {32'd0, raw[31:0]});

  always_comb begin
    eff = wr_data;
    if (bit_en && (wide || !bit_pos[5])) eff[bit_pos] = bit_val;
  end

  assign srf_wdata  = eff;
  assign srf_we_lo  = wr_en & ~err & to_srf;
  assign srf_we_hi  = wr_en & ~err & to_srf & wide;
  assign misc_we    = wr_en & ~err & (kind == K_MISC);
  assign misc_addr  = sel[MISC_W-1:0];
  assign misc_wdata = eff[31:0];
  assign exec_mask  = exec_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) exec_q <= EXEC_RST;
    else if (wr_en && !err && kind == K_EXEC) exec_q <= eff;
  end

endmodule

module sopnd_resolver_chk #(
  parameter int SEL_W = 8,
  parameter logic [7:0] EXEC_SEL = 8'h7E
) (
  input logic             clk,
  input logic             rst_n,
  input logic [SEL_W-1:0] sel,
  input logic             wide,
  input logic             wr_en,
  input logic [63:0]      wr_data,
  input logic             bit_en,
  input logic [63:0]      rd_data,
  input logic             err,
  input logic             srf_we_lo,
  input logic             srf_we_hi,
  input logic             misc_we,
  input logic [63:0]      exec_mask
);
  logic exec_wr;
  assign exec_wr = wr_en && wide && (sel == SEL_W'(EXEC_SEL));

  p_err_zero_r13: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> rd_data == 64'd0);
  p_err_blocks_r13: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> !(srf_we_lo || misc_we));
  p_exec_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_wr && !bit_en) |=> exec_mask == $past(wr_data));
  p_exec_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !exec_wr |=> $stable(exec_mask));
  p_hi_needs_lo_r11: assert property (@(posedge clk) disable iff (!rst_n)
    srf_we_hi |-> (srf_we_lo && wide));
  p_one_target_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({srf_we_lo, misc_we}));
endmodule

bind sopnd_resolver sopnd_resolver_chk #(.SEL_W(SEL_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .sel(sel), .wide(wide), .wr_en(wr_en),
  .wr_data(wr_data), .bit_en(bit_en), .rd_data(rd_data), .err(err),
  .srf_we_lo(srf_we_lo), .srf_we_hi(srf_we_hi), .misc_we(misc_we),
  .exec_mask(exec_mask)
);

// File: tb/sopnd_resolver_tb_top.sv
module sopnd_resolver_tb_top;
  localparam int IDX_W = 7;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [7:0] sel = '0;
  logic wide = 1'b0, wr_en = 1'b0, bit_en = 1'b0, bit_val = 1'b0;
  logic [31:0] lit = 32'hCAFE_0123;
  logic [IDX_W-1:0] rsv_cnt = 7'd40, sgpr_base = 7'd16;
  logic [IDX_W-1:0] srf_idx_lo, srf_idx_hi;
  logic [31:0] srf_rd_lo, srf_rd_hi, misc_rd, misc_wdata;
  logic [63:0] wr_data = '0, rd_data, srf_wdata, exec_mask;
  logic [5:0] bit_pos = '0;
  logic err, srf_we_lo, srf_we_hi, misc_we;
  logic [3:0] misc_addr;
  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  function automatic logic [31:0] rf(input logic [IDX_W-1:0] i);
    return {8'h5A, 1'b0, i, 16'hC3C3 ^ {9'd0, i}};
  endfunction
  function automatic logic [31:0] mv(input logic [3:0] a);
    return 32'h7E12_0000 | {28'd0, a};
  endfunction

  assign srf_rd_lo = rf(srf_idx_lo);
  assign srf_rd_hi = rf(srf_idx_hi);
  assign misc_rd   = mv(misc_addr);

  sopnd_resolver dut_i (
    .clk(clk), .rst_n(rst_n), .sel(sel), .wide(wide), .lit(lit),
    .rsv_cnt(rsv_cnt), .sgpr_base(sgpr_base), .srf_idx_lo(srf_idx_lo),
    .srf_idx_hi(srf_idx_hi), .srf_rd_lo(srf_rd_lo), .srf_rd_hi(srf_rd_hi),
    .misc_rd(misc_rd), .wr_en(wr_en), .wr_data(wr_data), .bit_en(bit_en),
    .bit_pos(bit_pos), .bit_val(bit_val), .rd_data(rd_data), .err(err),
    .srf_we_lo(srf_we_lo), .srf_we_hi(srf_we_hi), .srf_wdata(srf_wdata),
    .misc_we(misc_we), .misc_addr(misc_addr), .misc_wdata(misc_wdata),
    .exec_mask(exec_mask)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] sp_k(input int k);
    case (k)
      0: return 32'h3F000000; 1: return 32'hBF000000;
      2: return 32'h3F800000; 3: return 32'hBF800000;
      4: return 32'h40000000; 5: return 32'hC0000000;
      6: return 32'h40800000; default: return 32'hC0800000;
    endcase
  endfunction
  function automatic real rv_k(input int k);
    real m;
    m = (k / 2 == 0) ? 0.5 : (k / 2 == 1) ? 1.0 : (k / 2 == 2) ? 2.0 : 4.0;
    return (k % 2 == 1) ? -m : m;
  endfunction

  task automatic sweep(input logic [63:0] mask_now);
    for (int w = 0; w < 2; w++) begin
      for (int s = 0; s < 256; s++) begin
        logic [63:0] e;
        bit ee;
        string rq;
        int lg;
        @(negedge clk); sel = 8'(s); wide = w[0]; #2;
        ee = 1'b0; e = '0; rq = "R13"; lg = -1;
        if (s < 102) begin rq = "R1"; lg = s; end
        else if (s == 'h66) begin rq = "R3"; lg = int'(rsv_cnt) - 4; ee = (w == 1); end
        else if (s == 'h67) begin rq = "R3"; lg = int'(rsv_cnt) - 3; end
        else if (s == 'h6A) begin rq = "R2"; lg = int'(rsv_cnt) - 2; end
        else if (s >= 'h70 && s <= 'h7D) begin rq = "R10"; e = {32'd0, mv(4'(s))}; end
        else if (s == 'h7E) begin rq = "R8"; ee = (w == 0); e = mask_now; end
        else if (s >= 'hF0 && s <= 'hF7) begin
          rq = w ? "R5" : "R4";
          e = w ? $realtobits(rv_k(s - 'hF0)) : {32'd0, sp_k(s - 'hF0)};
        end
        else if (s == 'hF8) begin rq = "R6"; e = w ? 64'h3FC45F306DC9C882 : 64'h3E22F983; end
        else if (s >= 'hFD) begin rq = "R7"; ee = (w == 1); e = {32'd0, lit}; end
        else ee = 1'b1;
        if (lg >= 0) begin
          logic [IDX_W-1:0] pl;
          pl = sgpr_base + IDX_W'(lg);
          e = w ? {rf(pl + 7'd1), rf(pl)} : {32'd0, rf(pl)};
        end
        if (ee) e = '0;
        chk(err == ee, rq, {63'd0, err}, {63'd0, ee});
        chk(rd_data == e, rq, rd_data, e);
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++; n_run++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk); sel = 8'h7E; wide = 1'b1; #2;
    chk(exec_mask == '1 && rd_data == '1, "R8 reset mask", rd_data, '1);
    chk(!srf_we_lo && !misc_we, "R13 idle no write", {62'd0, srf_we_lo, misc_we}, 0);
    sweep('1);
    rsv_cnt = 7'd8; sgpr_base = 7'd0;
    sweep('1);
    rsv_cnt = 7'd40; sgpr_base = 7'd16;

    @(negedge clk); sel = 8'd5; wide = 1'b0; wr_en = 1'b1; wr_data = 64'h1111_2222_3333_4444; #2;
    chk(srf_we_lo && !srf_we_hi && srf_idx_lo == 7'd21 && srf_wdata[31:0] == 32'h3333_4444,
        "R11 narrow write", {srf_we_lo, srf_we_hi, srf_idx_lo, srf_wdata[31:0]}, {2'b10, 7'd21, 32'h33334444});
    @(negedge clk); sel = 8'h6A; wide = 1'b1; #2;
    chk(srf_we_lo && srf_we_hi && srf_idx_lo == 7'd54 && srf_idx_hi == 7'd55 && srf_wdata == wr_data,
        "R2 R11 wide vcond write", {srf_we_lo, srf_we_hi, srf_idx_lo, srf_idx_hi}, {2'b11, 7'd54, 7'd55});
    @(negedge clk); sel = 8'h66; wide = 1'b1; #2;
    chk(err && !srf_we_lo, "R3 wide flat-lo write blocked", {err, srf_we_lo}, 2'b10);
    @(negedge clk); sel = 8'h73; wide = 1'b0; #2;
    chk(misc_we && !srf_we_lo && misc_addr == 4'd3 && misc_wdata == 32'h3333_4444,
        "R10 misc write", {misc_we, misc_addr, misc_wdata}, {1'b1, 4'd3, 32'h33334444});
    @(negedge clk); sel = 8'hF0; #2;
    chk(!err && !srf_we_lo && !srf_we_hi && !misc_we, "R13 const write ignored",
        {srf_we_lo, srf_we_hi, misc_we}, 0);
    @(negedge clk); sel = 8'hFE; #2;
    chk(!srf_we_lo && !misc_we, "R13 literal write ignored", {srf_we_lo, misc_we}, 0);
    @(negedge clk); sel = 8'h6B; wide = 1'b0; #2;
    chk(err && !srf_we_lo && !misc_we, "R13 bad selector write", {err, srf_we_lo, misc_we}, 3'b100);

    @(negedge clk); sel = 8'd9; wide = 1'b1; wr_data = '0; bit_en = 1'b1; bit_pos = 6'd40; bit_val = 1'b1; #2;
    chk(srf_wdata == 64'h0000_0100_0000_0000, "R12 wide set bit 40", srf_wdata, 64'h0000_0100_0000_0000);
    @(negedge clk); wide = 1'b0; #2;
    chk(srf_wdata == 64'd0, "R12 narrow bit 40 no effect", srf_wdata, 0);
    @(negedge clk); wr_data = '1; bit_pos = 6'd3; bit_val = 1'b0; #2;
    chk(srf_wdata == ~64'd8, "R12 clear bit 3", srf_wdata, ~64'd8);

    @(negedge clk); bit_en = 1'b0; sel = 8'h7E; wide = 1'b1; wr_data = 64'h0123_4567_89AB_CDEF;
    @(negedge clk); wr_en = 1'b0; #2;
    chk(exec_mask == 64'h0123_4567_89AB_CDEF && rd_data == exec_mask, "R9 exec write", rd_data, 64'h0123_4567_89AB_CDEF);
    @(negedge clk); wr_en = 1'b1; wide = 1'b0; wr_data = '0; #2;
    chk(err == 1'b1, "R9 narrow exec write err", {63'd0, err}, 1);
    @(negedge clk); wr_en = 1'b0; wide = 1'b1; #2;
    chk(rd_data == 64'h0123_4567_89AB_CDEF, "R9 narrow exec write ignored", rd_data, 64'h0123_4567_89AB_CDEF);
    @(negedge clk); wr_en = 1'b1; bit_en = 1'b1; bit_pos = 6'd63; bit_val = 1'b1; wr_data = 64'h5;
    @(negedge clk); wr_en = 1'b0; bit_en = 1'b0; #2;
    chk(exec_mask == 64'h8000_0000_0000_0005, "R12 exec bit replace", exec_mask, 64'h8000_0000_0000_0005);
    sweep(64'h8000_0000_0000_0005);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule